// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 interrupt request lines and presents a single interrupt to a processor. Each source has a small control word that sets its enable, its trigger sense (either edge or either level), and a 3-bit priority level. Among the sources that are enabled and pending, the block picks the most urgent one that the current global mask threshold lets through. It raises `irqOut` while such a source exists.

Software reaches the control words, the mask threshold and a status word through a synchronous register port. Read data appears one clock after the address. When the processor acknowledges, the block records the accepted source number and the threshold that was in force before the acknowledge. It then raises the threshold to the accepted source's level, so that only sources that are strictly more urgent can interrupt the handler. Request inputs may be asynchronous and pass through a two-flop synchronizer.

Top module: `prio_intc`

## Requirements
- R1: Source control word, at address `0x40 + n`: bits [2:0] level, bits [4:3] sense, bit [5] request, bit [6] enable. It reads back what was written, with the request bit showing the live pending state. After reset every implemented word reads 0x07: level 7, sense 00, not pending, disabled.
- R2: The sense field has four modes. 00 is falling edge, 01 is low level, 10 is rising edge and 11 is high level. An edge mode sets the request bit only on its own edge direction.
- R3: A source at level 7 never raises `irqOut`, whatever its enable and request.
- R4: The mask register at address 0x01 holds a threshold N in bits [2:0], reset 0. Only sources with level strictly below N can interrupt, so N = 0 blocks everything.
- R5: The status word at address 0x00 reads as follows. Bits [31:28] hold the `VEC_BASE` parameter, bits [27:22] the last accepted source number, bits [18:16] the threshold in force before that acceptance, and all other bits are zero. It resets to `VEC_BASE` in bits [31:28] and zeros elsewhere.
- R6: Only sources 1–8, 16–21, 32–33, 48–51 and 56–63 exist. Every other source word reads zero, ignores writes and never interrupts.
- R7: The lowest level among eligible sources wins. If two or more eligible sources share that level, the lowest source number wins.
- R8: In an edge mode the request bit stays set until software writes 0 to it. Writing 1 neither sets nor clears it. In a level mode the request bit follows the synchronized input, and writes to it have no effect.
- R9: For a high-level source that is enabled and below the mask, suppose the input first reads high at rising edge k. Then `irqOut` is low after edge k+1 and high after edge k+2.
- R10: When `irqAck` is high at a clock edge and an eligible winner exists, three things happen at that edge. The status word captures the winner's number and the old threshold, and the threshold becomes the winner's level. An acknowledge with no eligible winner changes nothing.
- R11: `irqOut` is a registered output. It goes high one clock after an eligible source appears and low one clock after none remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 7 | Word address: bit 6 selects a source word, bits [5:0] the source or register |
| regWrData | input | 7 | Write data (widest writable field is 7 bits) |
| regRdData | output | 32 | Read data for the address of the previous cycle |
| reqIn | input | 64 | Asynchronous request lines, one per source number |
| irqOut | output | 1 | Interrupt request to the processor |
| irqAck | input | 1 | Interrupt acknowledge from the processor |

## Verification
The checker assumes two things about the processor side. It raises `irqAck` only for single cycles. It writes the mask register only when no acknowledge is being taken, although the design gives the acknowledge priority if both happen. The bench obeys both by pulsing the acknowledge for one cycle. It also changes requests and register writes on the falling clock edge and holds each request level for several cycles, well beyond the synchronizer's two-flop window. Because of that, edge-mode sources see clean single transitions and never see glitches narrower than a clock.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int LVL_W   = 3;
  localparam int SENSE_W = 2;

  // Trigger sense encoding; bit 0 set means a level mode, bit 1 set means active high / rising.
  typedef enum logic [SENSE_W-1:0] {
    SENSE_FALL = 2'b00,
    SENSE_LOW  = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_e;

  // Per-source control word as seen on the register port.
  typedef struct packed {
    logic               en;
    logic               req;
    logic [SENSE_W-1:0] sense;
    logic [LVL_W-1:0]   lvl;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic  srcWr;
    ctrl_t wrWord;
  } strobe_t;

endpackage

// File: rtl/intc_src_slice.sv
module intc_src_slice
  import intc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqIn,
  input  logic  wrEn,
  input  ctrl_t wrWord,
  output ctrl_t ctrlOut
);

  logic             syncA, syncB, prevB;
  logic             enQ, flagQ;
  logic [SENSE_W-1:0] senseQ;
  logic [LVL_W-1:0] lvlQ;
  logic             edgeHit, liveReq;

  // Edge event for the currently programmed edge mode.
  always_comb begin
    if (senseQ[0]) edgeHit = 1'b0;
    else if (senseQ[1]) edgeHit = syncB & ~prevB;
    else edgeHit = ~syncB & prevB;
  end

  assign liveReq = senseQ[0] ? (syncB ~^ senseQ[1]) : flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      prevB  <= 1'b0;
      enQ    <= 1'b0;
      senseQ <= SENSE_FALL;
      lvlQ   <= '1;
      flagQ  <= 1'b0;
    end else begin
      syncA <= reqIn;
      syncB <= syncA;
      prevB <= syncB;
      if (wrEn) begin
        enQ    <= wrWord.en;
        senseQ <= wrWord.sense;
        lvlQ   <= wrWord.lvl;
      end
      if (edgeHit) flagQ <= 1'b1;
      else if (wrEn && (!wrWord.req || wrWord.sense[0])) flagQ <= 1'b0;
    end
  end

  assign ctrlOut = '{en: enQ, req: liveReq, sense: senseQ, lvl: lvlQ};

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  ctrl_t            ctrlArr [NUM_SRC],
  input  logic [LVL_W-1:0] maskLvl,
  output logic             winValid,
  output logic [SRC_W-1:0] winIdx,
  output logic [LVL_W-1:0] winLvl
);

  // Ascending scan with strict compare keeps the lowest number on a level tie.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLvl   = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ctrlArr[i].en && ctrlArr[i].req && (ctrlArr[i].lvl < maskLvl) &&
          (!winValid || (ctrlArr[i].lvl < winLvl))) begin
        winValid = 1'b1;
        winIdx   = SRC_W'(i);
        winLvl   = ctrlArr[i].lvl;
      end
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int           NUM_SRC   = 64,
  parameter logic [63:0]  IMPL_MASK = 64'hFF0F_0003_003F_01FE,
  localparam int          SRC_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  strobe_t            stb,
  input  logic [SRC_W-1:0]   srcIdx,
  input  logic [LVL_W-1:0]   maskLvl,
  output ctrl_t              srcRdWord,
  output logic               winValid,
  output logic [SRC_W-1:0]   winIdx,
  output logic [LVL_W-1:0]   winLvl
);

  ctrl_t ctrlArr [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (IMPL_MASK[i]) begin : g_impl
      intc_src_slice u_slice (
        .clk     (clk),
        .rstN    (rstN),
        .reqIn   (reqIn[i]),
        .wrEn    (stb.srcWr && (srcIdx == SRC_W'(i))),
        .wrWord  (stb.wrWord),
        .ctrlOut (ctrlArr[i])
      );
    end else begin : g_hole
      assign ctrlArr[i] = '0;
    end
  end

  assign srcRdWord = ctrlArr[srcIdx];

  intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .ctrlArr  (ctrlArr),
    .maskLvl  (maskLvl),
    .winValid (winValid),
    .winIdx   (winIdx),
    .winLvl   (winLvl)
  );

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int         NUM_SRC  = 64,
  parameter int         DATA_W   = 32,
  parameter logic [3:0] VEC_BASE = 4'hA,
  localparam int        SRC_W    = $clog2(NUM_SRC),
  localparam int        ADDR_W   = SRC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              irqAck,
  input  ctrl_t             srcRdWord,
  input  logic              winValid,
  input  logic [SRC_W-1:0]  winIdx,
  input  logic [LVL_W-1:0]  winLvl,
  output strobe_t           stb,
  output logic [SRC_W-1:0]  srcIdx,
  output logic [LVL_W-1:0]  maskLvl,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  localparam logic [SRC_W-1:0] STATUS_SEL = SRC_W'(0);
  localparam logic [SRC_W-1:0] MASK_SEL   = SRC_W'(1);

  logic             isSrc, isStatus, isMask, ackTake;
  logic [SRC_W-1:0] accSrc;
  logic [LVL_W-1:0] prevLvl;

  assign isSrc    = regAddr[ADDR_W-1];
  assign srcIdx   = regAddr[SRC_W-1:0];
  assign isStatus = !isSrc && (regAddr[SRC_W-1:0] == STATUS_SEL);
  assign isMask   = !isSrc && (regAddr[SRC_W-1:0] == MASK_SEL);
  assign ackTake  = irqAck && winValid;

  assign stb.srcWr  = regWr && isSrc;
  assign stb.wrWord = ctrl_t'(regWrData);

  assign statusWord = {VEC_BASE, 6'(accSrc), 3'b000, prevLvl, 16'h0000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLvl   <= '0;
      accSrc    <= '0;
      prevLvl   <= '0;
      irqOut    <= 1'b0;
      regRdData <= '0;
    end else begin
      if (ackTake) begin
        prevLvl <= maskLvl;
        accSrc  <= winIdx;
        maskLvl <= winLvl;
      end else if (regWr && isMask) begin
        maskLvl <= regWrData[LVL_W-1:0];
      end
      irqOut <= winValid;
      if (isSrc) regRdData <= DATA_W'(srcRdWord);
      else if (isStatus) regRdData <= statusWord;
      else if (isMask) regRdData <= DATA_W'(maskLvl);
      else regRdData <= '0;
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int          NUM_SRC   = 64,
  parameter int          DATA_W    = 32,
  parameter logic [3:0]  VEC_BASE  = 4'hA,
  parameter logic [63:0] IMPL_MASK = 64'hFF0F_0003_003F_01FE,
  localparam int         SRC_W     = $clog2(NUM_SRC),
  localparam int         ADDR_W    = SRC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic              irqOut,
  input  logic              irqAck
);

  strobe_t          stb;
  logic [SRC_W-1:0] srcIdx;
  logic [LVL_W-1:0] maskLvl;
  logic [DATA_W-1:0] statusWord;
  ctrl_t            srcRdWord;
  logic             winValid;
  logic [SRC_W-1:0] winIdx;
  logic [LVL_W-1:0] winLvl;

  intc_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .irqAck     (irqAck),
    .srcRdWord  (srcRdWord),
    .winValid   (winValid),
    .winIdx     (winIdx),
    .winLvl     (winLvl),
    .stb        (stb),
    .srcIdx     (srcIdx),
    .maskLvl    (maskLvl),
    .statusWord (statusWord),
    .regRdData  (regRdData),
    .irqOut     (irqOut)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .IMPL_MASK(IMPL_MASK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .stb       (stb),
    .srcIdx    (srcIdx),
    .maskLvl   (maskLvl),
    .srcRdWord (srcRdWord),
    .winValid  (winValid),
    .winIdx    (winIdx),
    .winLvl    (winLvl)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int          NUM_SRC   = 64,
  parameter int          DATA_W    = 32,
  parameter logic [3:0]  VEC_BASE  = 4'hA,
  parameter logic [63:0] IMPL_MASK = 64'hFF0F_0003_003F_01FE,
  localparam int         SRC_W     = $clog2(NUM_SRC),
  localparam int         ADDR_W    = SRC_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              irqOut,
  input logic              irqAck,
  input logic [LVL_W-1:0]  maskLvl,
  input logic [DATA_W-1:0] statusWord,
  input logic              winValid,
  input logic [SRC_W-1:0]  winIdx,
  input logic [LVL_W-1:0]  winLvl
);

  // R4: a zero threshold silences the interrupt on the following cycle.
  a_r4_zero_mask_silent: assert property (@(posedge clk) disable iff (!rstN)
    (maskLvl == '0) |=> !irqOut);

  // R10: an accepted acknowledge moves threshold into status and raises it.
  a_r10_ack_moves_mask: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && winValid) |=> ((statusWord[18:16] == $past(maskLvl)) &&
                              (maskLvl == $past(winLvl)) &&
                              (statusWord[27:22] == 6'($past(winIdx)))));

  // R6: the recorded source is always an existing one (or the reset zero).
  a_r6_status_src_exists: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[27:22] == 6'd0) || IMPL_MASK[statusWord[27:22]]);

  // R6: missing source words read as zero.
  a_r6_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[ADDR_W-1] && !IMPL_MASK[regAddr[SRC_W-1:0]]) |=> (regRdData == '0));

  // R5: the vector base field never changes.
  a_r5_vector_base: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:28] == VEC_BASE);

  // R3: a level-7 source can never be the selected winner.
  a_r3_no_level7_winner: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winLvl != '1));

endmodule

bind prio_intc intc_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regRdData  (regRdData),
  .irqOut     (irqOut),
  .irqAck     (irqAck),
  .maskLvl    (maskLvl),
  .statusWord (statusWord),
  .winValid   (winValid),
  .winIdx     (winIdx),
  .winLvl     (winLvl)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;

  localparam real CLK_NS = 20.0;
  localparam logic [31:0] VB = 32'hA000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [6:0]  regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] reqIn = '0;
  logic        irqOut;
  logic        irqAck = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqIn(reqIn),
    .irqOut(irqOut), .irqAck(irqAck)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [6:0] a, input logic [6:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    @(posedge clk);
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic ack();
    @(negedge clk);
    irqAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  function automatic logic [6:0] srcAddr(input int n);
    return 7'h40 | 7'(n);
  endfunction

  task automatic chkRd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rdReg(a, d);
    check(d == exp, tag, d, exp);
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    check(irqOut == exp, tag, 32'(irqOut), 32'(exp));
  endtask

  // Reset state: R1, R4, R5, R11
  task automatic tReset();
    chkIrq(1'b0, "R11 irq low after reset");
    chkRd(7'h00, VB, "R5 status reset");
    chkRd(7'h01, 32'h0, "R4 mask reset");
    chkRd(srcAddr(1), 32'h07, "R1 source word reset");
  endtask

  // R1: control word write/read
  task automatic tCtrlRw();
    wrReg(srcAddr(3), 7'h5A);
    chkRd(srcAddr(3), 32'h5A, "R1 control readback");
    wrReg(srcAddr(3), 7'h07);
  endtask

  // R6: hole source
  task automatic tHole();
    reqIn[10] = 1'b1;
    wrReg(srcAddr(10), 7'h5A);
    chkRd(srcAddr(10), 32'h0, "R6 hole reads zero");
    wrReg(7'h01, 7'd7);
    waitCyc(5);
    chkIrq(1'b0, "R6 hole never interrupts");
    reqIn[10] = 1'b0;
    wrReg(7'h01, 7'd0);
  endtask

  // R9 latency, R2 high level, R11 drop
  task automatic tLatency();
    wrReg(srcAddr(2), 7'h5B);
    wrReg(7'h01, 7'd7);
    @(negedge clk);
    reqIn[2] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chkIrq(1'b0, "R9 irq still low after edge k+1");
    @(posedge clk);
    @(negedge clk);
    chkIrq(1'b1, "R9 irq high after edge k+2");
    reqIn[2] = 1'b0;
    waitCyc(4);
    chkIrq(1'b0, "R11 irq drops with high-level input");
  endtask

  // R4 threshold
  task automatic tMask();
    reqIn[2] = 1'b1;
    wrReg(7'h01, 7'd3);
    waitCyc(4);
    chkIrq(1'b0, "R4 level 3 blocked by mask 3");
    wrReg(7'h01, 7'd4);
    waitCyc(2);
    chkIrq(1'b1, "R4 level 3 passes mask 4");
    wrReg(7'h01, 7'd0);
    waitCyc(2);
    chkIrq(1'b0, "R4 mask 0 blocks all");
    reqIn[2] = 1'b0;
    wrReg(srcAddr(2), 7'h07);
  endtask

  // R3 level 7
  task automatic tLevel7();
    wrReg(srcAddr(4), 7'h5F);
    wrReg(7'h01, 7'd7);
    reqIn[4] = 1'b1;
    waitCyc(5);
    chkIrq(1'b0, "R3 level 7 silent");
    chkRd(srcAddr(4), 32'h7F, "R3 level 7 still shows pending");
    reqIn[4] = 1'b0;
    wrReg(srcAddr(4), 7'h07);
    wrReg(7'h01, 7'd0);
  endtask

  // R7 priority, R10 acknowledge, R5 status layout
  task automatic tPriority();
    wrReg(7'h01, 7'd7);
    wrReg(srcAddr(17), 7'h5A);
    wrReg(srcAddr(18), 7'h5A);
    reqIn[17] = 1'b1;
    reqIn[18] = 1'b1;
    waitCyc(4);
    chkIrq(1'b1, "R11 irq with two pending");
    ack();
    chkRd(7'h00, VB | (32'd17 << 22) | (32'd7 << 16), "R7 tie lowest number, R5 status");
    chkRd(7'h01, 32'd2, "R10 mask raised to level 2");
    waitCyc(2);
    chkIrq(1'b0, "R10 equal level blocked after ack");
    wrReg(7'h01, 7'd7);
    wrReg(srcAddr(56), 7'h59);
    reqIn[56] = 1'b1;
    waitCyc(4);
    ack();
    chkRd(7'h00, VB | (32'd56 << 22) | (32'd7 << 16), "R7 lower level beats lower number");
    chkRd(7'h01, 32'd1, "R10 mask raised to level 1");
    ack();
    chkRd(7'h00, VB | (32'd56 << 22) | (32'd7 << 16), "R10 ack without winner ignored (status)");
    chkRd(7'h01, 32'd1, "R10 ack without winner ignored (mask)");
    reqIn[17] = 1'b0; reqIn[18] = 1'b0; reqIn[56] = 1'b0;
    wrReg(srcAddr(17), 7'h07);
    wrReg(srcAddr(18), 7'h07);
    wrReg(srcAddr(56), 7'h07);
    wrReg(7'h01, 7'd0);
  endtask

  // R8 sticky edge flag, R2 rising and falling
  task automatic tEdge();
    wrReg(7'h01, 7'd7);
    wrReg(srcAddr(33), 7'h51);
    reqIn[33] = 1'b1;
    waitCyc(3);
    reqIn[33] = 1'b0;
    waitCyc(4);
    chkIrq(1'b1, "R8 rising edge held after input drops");
    chkRd(srcAddr(33), 32'h71, "R2 rising edge sets request");
    wrReg(srcAddr(33), 7'h71);
    chkRd(srcAddr(33), 32'h71, "R8 writing 1 keeps request");
    wrReg(srcAddr(33), 7'h51);
    chkRd(srcAddr(33), 32'h51, "R8 writing 0 clears request");
    waitCyc(2);
    chkIrq(1'b0, "R8 irq gone after clear");
    wrReg(srcAddr(32), 7'h41);
    reqIn[32] = 1'b1;
    waitCyc(5);
    chkRd(srcAddr(32), 32'h41, "R2 falling mode ignores rise");
    chkIrq(1'b0, "R2 no irq on rise in falling mode");
    reqIn[32] = 1'b0;
    waitCyc(5);
    chkRd(srcAddr(32), 32'h61, "R2 falling edge sets request");
    chkIrq(1'b1, "R2 falling edge raises irq");
    wrReg(srcAddr(32), 7'h07);
    wrReg(srcAddr(33), 7'h07);
    wrReg(7'h01, 7'd0);
  endtask

  // R2 low level, R8 level ignores writes
  task automatic tLevelLow();
    wrReg(srcAddr(48), 7'h4D);
    waitCyc(3);
    chkRd(srcAddr(48), 32'h6D, "R2 low level pending while input low");
    wrReg(srcAddr(48), 7'h4D);
    chkRd(srcAddr(48), 32'h6D, "R8 level mode ignores request write");
    reqIn[48] = 1'b1;
    waitCyc(4);
    chkRd(srcAddr(48), 32'h4D, "R2 low level clears when input high");
    wrReg(srcAddr(48), 7'h07);
    reqIn[48] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCtrlRw();
    tHole();
    tLatency();
    tMask();
    tLevel7();
    tPriority();
    tEdge();
    tLevelLow();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule